// File: doc/BRIEF.md
# Board Control Register Block with Card-Slot Interrupt

This block is a small set of board control registers on a plain 32-bit register bus. A byte address inside a window of 0x00800000 bytes selects a register by its word index, which is the address shifted right by two. Two of the registers return fixed words: one identifies the board and one describes the address decode. A third register holds the card-slot status word. The fourth reads as zero.

The status word takes two inputs from an SD/MMC host controller. One bit follows the write-protect level. A second, sticky bit records that a card was inserted. The sticky bit drives a level interrupt line towards a secondary interrupt controller. Software acknowledges a card event by writing a one to that bit's position in the status register. Both card-slot inputs are taken to be synchronous to the bus clock already.

The bus has no handshake. A read returns its data on `bus_rdata` one clock after `bus_rd` is sampled high, and that value holds until the next read. A write takes effect on the clock edge where `bus_wr` is sampled high.

Top module: `brd_ctl_regs`

## Requirements
- R1: While reset is active, and on the first cycle after it ends, `irq_out` is 0, `bus_rdata` is 0 and the status word is 0.
- R2: A read at word index 0 returns 0x41034003 on the cycle after the read. Byte-address bits [1:0] do not affect which register is selected.
- R3: A read at word index 1 returns 0. A read at word index 3 returns 0x00000011.
- R4: A read at word index 2 returns the status word. Bit 0 of the status word equals the level of `slot_wp` sampled on the previous clock.
- R5: Bit 3 of the status word becomes 1 on the clock after `slot_det` is sampled high. It stays 1 after `slot_det` returns low.
- R6: A write to word index 2 with data bit 3 equal to 1 clears status bit 3. With data bit 3 equal to 0 the write leaves bit 3 as it is. Written data never changes status bit 0, and the status bits other than 0 and 3 always read as 0.
- R7: `irq_out` is high exactly while status bit 3 is 1. It rises with the set and falls on the clock after a clearing write.
- R8: If `slot_det` is high in the same cycle as a clearing write, the set wins: bit 3 stays 1 and `irq_out` stays high.
- R9: A read at any word index from 4 up to the top of the window returns 0. Writes to word indices 1, 3 and 4 and above change neither the status word nor `irq_out`.
- R10: `bus_rdata` keeps the value of the last read for as long as no new read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 23 | Byte address inside the register window |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read |
| slot_wp | input | 1 | Write-protect level from the card slot |
| slot_det | input | 1 | Card-inserted level from the card slot |
| irq_out | output | 1 | Level interrupt that follows the sticky card-inserted bit |

## Verification
The hardest case to reach is a clearing write that lands in the same clock as a high card-inserted input. The bench raises `slot_det` and issues the status write in the same cycle, drops `slot_det` at once, and then checks that the interrupt is still high and that the status word still reads bit 3 set. A related case is a write whose data has every bit set except bit 3. It must leave the sticky bit alone, and the bench checks this both at `irq_out` and by reading the status word back.

// File: rtl/brd_ctl_pkg.sv
package brd_ctl_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam logic [31:0] ID_WORD  = 32'h4103_4003;
  localparam logic [31:0] DEC_WORD = 32'h0000_0011;
  localparam int unsigned WP_BIT   = 0;
  localparam int unsigned DET_BIT  = 3;

  typedef enum int unsigned {
    IDX_ID    = 0,
    IDX_FLASH = 1,
    IDX_STAT  = 2,
    IDX_DEC   = 3
  } reg_idx_e;

  localparam int unsigned NUM_REG = 4;
endpackage

// File: rtl/brd_ctl_decode.sv
module brd_ctl_decode #(
  parameter int unsigned ADDR_W  = 23,
  parameter int unsigned NUM_REG = 4
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rd,
  input  logic               wr,
  output logic [NUM_REG-1:0] rd_sel,
  output logic [NUM_REG-1:0] wr_sel
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;
  logic [1:0]       unused_byte_lane;

  assign word_idx         = addr[ADDR_W-1:2];
  assign unused_byte_lane = addr[1:0];

  for (genvar g = 0; g < NUM_REG; g++) begin : g_sel
    logic hit;
    assign hit       = (word_idx == IDX_W'(g));
    assign rd_sel[g] = rd & hit;
    assign wr_sel[g] = wr & hit;
  end
endmodule

// File: rtl/brd_ctl_status.sv
module brd_ctl_status
  import brd_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_lvl,
  input  logic              det_lvl,
  input  logic              ack_det,
  output logic [DATA_W-1:0] stat
);
  logic wp_q;
  logic det_q;
  logic det_d;

  // A card event raised in the same cycle as an acknowledge is kept.
  assign det_d = det_lvl | (det_q & ~ack_det);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= 1'b0;
      det_q <= 1'b0;
    end else begin
      wp_q  <= wp_lvl;
      det_q <= det_d;
    end
  end

  always_comb begin
    stat          = '0;
    stat[WP_BIT]  = wp_q;
    stat[DET_BIT] = det_q;
  end
endmodule

// File: rtl/brd_ctl_rdmux.sv
module brd_ctl_rdmux
  import brd_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [NUM_REG-1:0] rd_sel,
  input  logic [DATA_W-1:0] stat,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] src [NUM_REG];
  logic [DATA_W-1:0] mux_out;

  always_comb begin
    src[IDX_ID]    = ID_WORD;
    src[IDX_FLASH] = '0;
    src[IDX_STAT]  = stat;
    src[IDX_DEC]   = DEC_WORD;
  end

  // One-hot AND-OR selection: no hit (out-of-range index) yields zero.
  always_comb begin
    mux_out = '0;
    for (int i = 0; i < NUM_REG; i++) begin
      mux_out = mux_out | (src[i] & {DATA_W{rd_sel[i]}});
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= mux_out;
    end
  end
endmodule

// File: rtl/brd_ctl_regs.sv
module brd_ctl_regs
  import brd_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              slot_wp,
  input  logic              slot_det,
  output logic              irq_out
);
  logic [NUM_REG-1:0] rd_sel;
  logic [NUM_REG-1:0] wr_sel;
  logic [DATA_W-1:0]  stat_word;
  logic               ack_det;
  logic [DATA_W-1:0]  unused_wdata;
  logic [NUM_REG-1:0] unused_wr_sel;

  brd_ctl_decode #(
    .ADDR_W  (ADDR_W),
    .NUM_REG (NUM_REG)
  ) u_decode (
    .addr   (bus_addr),
    .rd     (bus_rd),
    .wr     (bus_wr),
    .rd_sel (rd_sel),
    .wr_sel (wr_sel)
  );

  assign ack_det       = wr_sel[IDX_STAT] & bus_wdata[DET_BIT];
  assign unused_wdata  = bus_wdata;
  assign unused_wr_sel = wr_sel;

  brd_ctl_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .wp_lvl  (slot_wp),
    .det_lvl (slot_det),
    .ack_det (ack_det),
    .stat    (stat_word)
  );

  brd_ctl_rdmux u_rdmux (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd     (bus_rd),
    .rd_sel (rd_sel),
    .stat   (stat_word),
    .rdata  (bus_rdata)
  );

  assign irq_out = stat_word[DET_BIT];
endmodule

// File: rtl/brd_ctl_regs_chk.sv
module brd_ctl_regs_chk
  import brd_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 23
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              slot_wp,
  input logic              slot_det,
  input logic              irq_out,
  input logic [DATA_W-1:0] stat_word
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             stat_ack;
  assign idx      = bus_addr[ADDR_W-1:2];
  assign stat_ack = bus_wr && (idx == IDX_W'(IDX_STAT)) && bus_wdata[DET_BIT];

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!irq_out && bus_rdata == '0));

  p_id_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && idx == IDX_W'(IDX_ID)) |=> (bus_rdata == ID_WORD));

  p_wp_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (stat_word[WP_BIT] == $past(slot_wp)));

  p_det_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    slot_det |=> irq_out);

  p_det_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !stat_ack) |=> irq_out);

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_ack && !slot_det) |=> !irq_out);

  p_irq_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && idx == IDX_W'(IDX_STAT)) |=> (bus_rdata[DET_BIT] == $past(irq_out)));

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !bus_rd) |=> $stable(bus_rdata));
endmodule

bind brd_ctl_regs brd_ctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .slot_wp   (slot_wp),
  .slot_det  (slot_det),
  .irq_out   (irq_out),
  .stat_word (stat_word)
);

// File: tb/brd_ctl_regs_bench.sv
module brd_ctl_regs_bench;
  localparam int  CLK_PERIOD = 10;
  localparam int  ADDR_W     = 23;
  localparam int  WATCHDOG   = 200000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_rd = 1'b0;
  logic              bus_wr = 1'b0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              slot_wp = 1'b0;
  logic              slot_det = 1'b0;
  logic              irq_out;

  int checks = 0;
  int errors = 0;
  logic [31:0] q_exp [$];
  string       q_tag [$];
  logic        rd_q = 1'b0;

  brd_ctl_regs #(.ADDR_W(ADDR_W)) u_brd_ctl_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .slot_wp   (slot_wp),
    .slot_det  (slot_det),
    .irq_out   (irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) rd_q <= bus_rd;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: compares read data the cycle after each read.
  always @(negedge clk) begin
    if (rd_q) begin
      if (q_exp.size() == 0) begin
        check(bus_rdata, 32'hDEAD_BEEF, "scoreboard empty");
      end else begin
        check(bus_rdata, q_exp.pop_front(), q_tag.pop_front());
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  // Driver: issue a read and push the expected word.
  task automatic rd_word(input logic [ADDR_W-1:0] byte_addr, input logic [31:0] exp,
                         input string tag);
    bus_addr = byte_addr;
    bus_rd   = 1'b1;
    q_exp.push_back(exp);
    q_tag.push_back(tag);
    tick();
    bus_rd = 1'b0;
  endtask

  task automatic wr_word(input logic [ADDR_W-1:0] byte_addr, input logic [31:0] data);
    bus_addr  = byte_addr;
    bus_wdata = data;
    bus_wr    = 1'b1;
    tick();
    bus_wr    = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    slot_wp  = 1'b1;
    slot_det = 1'b1;
    repeat (3) tick();
    check({31'd0, irq_out}, 32'd0, "R1 irq in reset");
    check(bus_rdata, 32'd0, "R1 rdata in reset");
    slot_wp  = 1'b0;
    slot_det = 1'b0;
    rst_n    = 1'b1;
    rd_word(23'h8, 32'h0, "R1 status after reset");

    rd_word(23'h0, 32'h4103_4003, "R2 id word");
    rd_word(23'h3, 32'h4103_4003, "R2 id word low bits ignored");
    rd_word(23'h4, 32'h0, "R3 flash index reads zero");
    rd_word(23'hC, 32'h11, "R3 decode word");
    rd_word(23'h10, 32'h0, "R9 index 4 reads zero");
    rd_word(23'h7F_FFFC, 32'h0, "R9 last index reads zero");

    slot_wp = 1'b1; tick();
    rd_word(23'h8, 32'h1, "R4 wp high");
    slot_wp = 1'b0; tick();
    rd_word(23'h8, 32'h0, "R4 wp low");

    slot_det = 1'b1; tick();
    check({31'd0, irq_out}, 32'd1, "R7 irq rises with set");
    slot_det = 1'b0; tick();
    rd_word(23'h8, 32'h8, "R5 sticky after det low");
    check({31'd0, irq_out}, 32'd1, "R5 irq held");

    wr_word(23'h8, 32'hFFFF_FFF7);
    check({31'd0, irq_out}, 32'd1, "R6 write without bit3 keeps irq");
    rd_word(23'h8, 32'h8, "R6 write without bit3 keeps status");
    wr_word(23'h4, 32'hFFFF_FFFF);
    wr_word(23'hC, 32'hFFFF_FFFF);
    wr_word(23'h14, 32'hFFFF_FFFF);
    check({31'd0, irq_out}, 32'd1, "R9 other writes keep irq");
    rd_word(23'h8, 32'h8, "R9 other writes keep status");

    slot_wp = 1'b1; tick();
    wr_word(23'h8, 32'h0000_0009);
    check({31'd0, irq_out}, 32'd0, "R7 irq falls after clear");
    rd_word(23'h8, 32'h1, "R6 clear keeps bit0");

    slot_det = 1'b1;
    wr_word(23'h8, 32'h0000_0008);
    slot_det = 1'b0;
    check({31'd0, irq_out}, 32'd1, "R8 set wins irq");
    rd_word(23'h8, 32'h9, "R8 set wins status");

    repeat (4) tick();
    check(bus_rdata, 32'h9, "R10 rdata held while idle");
    rd_word(23'hC, 32'h11, "R10 new read replaces");
    repeat (2) tick();
    check(bus_rdata, 32'h11, "R10 rdata held after read");

    finish_run();
  end
endmodule